// File: doc/BRIEF.md
# Linear CCD Drive Clock Generator

This block produces every digital drive clock that a two-output linear CCD needs, with odd pixels leaving on one output and even pixels on the other. Each line starts with a transfer phase: a setup margin, a transfer-gate pulse, and a hold margin. During this phase the shift clocks are frozen and the reset and clamp clocks are held low. A readout phase follows, in which a pixel-phase counter drives the two-phase shift clocks, the last-stage clock, the reset gate, the clamp clock and a sampling strobe for each channel. Every timing value is a count of system-clock cycles.

Configuration inputs set three things: the three transfer-phase lengths, whether the clamp pulses once per pixel (bit clamp) or once per line (line clamp), and whether the even channel runs in step with the odd channel or half a pixel period behind it. The block latches these inputs only at the boundary between lines, so a line is never driven with a mix of settings. It also outputs a pixel-pair index and a region code, which capture logic downstream uses to tell dummy, optical-black, valid and trailing pixels apart.

Top module: `lccd_clkgen`

## Requirements
- R1: The transfer gate output `tg_o` goes high once per line, after the setup margin. It stays high for exactly `cfg_xfer_cyc` cycles. A length of 0 is treated as 1.
- R2: From the first setup cycle to the last hold cycle, `sh1_o` is 11 and `sh2_o` and `last_o` are 00. The setup margin lasts `cfg_setup_cyc` cycles and the hold margin lasts `cfg_hold_cyc` cycles, with 0 treated as 1.
- R3: The reset gate, clamp and sample outputs of both channels stay low through the setup margin, the transfer pulse and the hold margin.
- R4: Readout lasts (N_DUMMY+N_OB+N_VALID+N_INVALID)/2 pixel pairs of PIX_CYC cycles each. `pair_o` counts these pairs from 0. `region_o` encodes the region: 0 for dummy, 1 for optical black, 2 for valid, 3 for invalid, and the regions occur in that order. Outside readout, `region_o` and `pair_o` are 0.
- R5: In bit-clamp mode (`cfg_line_clamp`=0), each pixel period has two pulses on the odd channel. The reset gate is high for RST_W cycles starting at pixel phase RST_AT. The clamp is high for CLP_W cycles starting CLP_GAP cycles after the reset gate falls.
- R6: In line-clamp mode (`cfg_line_clamp`=1), the clamp has no per-pixel pulse. It is high for exactly the optical-black pair periods of each line. Reset gate pulses continue every pixel.
- R7: With `cfg_out_phase`=0, the even channel (bit 1 of each clock vector) is identical to the odd channel (bit 0). With `cfg_out_phase`=1, every even-channel clock follows pixel phase (p + PIX_CYC/2) mod PIX_CYC, which is half a pixel period away from the odd channel. PIX_CYC must be even.
- R8: The mode inputs and the three length inputs are sampled at reset and on the last readout cycle of each line. A change at any other time has no effect until the next line.
- R9: Each channel's `smp_o` bit is high for one cycle per pixel period, at the channel's pixel phase SMP_AT, and only in the valid region.
- R10: While reset is held, `tg_o`=0, `sh1_o`=11, all other clocks are 0, and `region_o` and `pair_o` are 0. Each output is registered and shows the sequencer state of the previous cycle. The first cycle after reset is line setup.
- R11: During readout, each channel's `sh1_o` is high for phases below PIX_CYC/2 and low otherwise. `sh2_o` and `last_o` are its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_setup_cyc | input | CNT_W | Setup margin before the transfer pulse, in cycles |
| cfg_xfer_cyc | input | CNT_W | Transfer-gate pulse width, in cycles |
| cfg_hold_cyc | input | CNT_W | Hold margin after the transfer pulse, in cycles |
| cfg_line_clamp | input | 1 | 1 = line clamp, 0 = bit clamp |
| cfg_out_phase | input | 1 | 1 = even channel half a pixel behind the odd channel |
| tg_o | output | 1 | Transfer gate |
| sh1_o | output | 2 | Shift clock phase 1 (bit 0 odd, bit 1 even) |
| sh2_o | output | 2 | Shift clock phase 2 |
| last_o | output | 2 | Last-stage shift clock |
| rg_o | output | 2 | Reset gate |
| cp_o | output | 2 | Feed-through clamp |
| smp_o | output | 2 | Valid-pixel sampling strobe |
| region_o | output | 2 | Region code of the current pixel pair |
| pair_o | output | PAIR_W | Pixel-pair index within readout |

## Verification
Every output comes from a register fed by the sequencer state. The value an output shows after clock edge k+n therefore belongs to sequencer step n, and step 0 is the first setup cycle after the first edge with reset low. The driver computes step n at edge k+n from the inputs present at that edge. When step n is the last step of a line, the driver also takes those same inputs as the next line's settings, because the design latches at that same edge. The monitor compares each output half a clock later, so configuration changes made mid-line line up with the line boundary where they take effect.

// File: rtl/lccd_pkg.sv
package lccd_pkg;

  typedef enum logic [1:0] {
    RG_DUMMY   = 2'd0,
    RG_OB      = 2'd1,
    RG_VALID   = 2'd2,
    RG_INVALID = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    ST_SETUP = 2'd0,
    ST_XFER  = 2'd1,
    ST_HOLD  = 2'd2,
    ST_READ  = 2'd3
  } seq_st_e;

endpackage

// File: rtl/lccd_line_seq.sv
module lccd_line_seq
  import lccd_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int N_DUMMY   = 32,
  parameter int N_OB      = 96,
  parameter int N_VALID   = 7400,
  parameter int N_INVALID = 6,
  parameter int PIX_CYC   = 10,
  parameter int PAIR_W    = 12,
  parameter int PH_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_setup,
  input  logic [CNT_W-1:0]  cfg_xfer,
  input  logic [CNT_W-1:0]  cfg_hold,
  input  logic              cfg_line_clamp,
  input  logic              cfg_out_phase,
  output logic              reading,
  output logic [PH_W-1:0]   phase,
  output logic              in_ob,
  output logic              in_valid,
  output logic              line_clamp_q,
  output logic              out_phase_q,
  output logic              xfer_o,
  output logic [1:0]        region_o,
  output logic [PAIR_W-1:0] pair_o
);

  localparam int NPAIR = (N_DUMMY + N_OB + N_VALID + N_INVALID) / 2;
  localparam logic [PAIR_W-1:0] LAST_PAIR = PAIR_W'(NPAIR - 1);
  localparam logic [PAIR_W-1:0] B_OB      = PAIR_W'(N_DUMMY / 2);
  localparam logic [PAIR_W-1:0] B_VAL     = PAIR_W'((N_DUMMY + N_OB) / 2);
  localparam logic [PAIR_W-1:0] B_INV     = PAIR_W'((N_DUMMY + N_OB + N_VALID) / 2);
  localparam logic [PH_W-1:0]   LAST_PH   = PH_W'(PIX_CYC - 1);
  localparam logic [CNT_W-1:0]  ONE       = CNT_W'(1);

  seq_st_e           st;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  setup_q, xfer_q, hold_q;
  logic [PAIR_W-1:0] pair;
  logic              line_end;
  region_e           region_now;

  assign reading  = (st == ST_READ);
  assign line_end = reading && (phase == LAST_PH) && (pair == LAST_PAIR);

  always_comb begin
    if (!reading)          region_now = RG_DUMMY;
    else if (pair < B_OB)  region_now = RG_DUMMY;
    else if (pair < B_VAL) region_now = RG_OB;
    else if (pair < B_INV) region_now = RG_VALID;
    else                   region_now = RG_INVALID;
  end

  assign in_ob    = (region_now == RG_OB);
  assign in_valid = (region_now == RG_VALID);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_SETUP;
      cnt          <= '0;
      phase        <= '0;
      pair         <= '0;
      setup_q      <= cfg_setup;
      xfer_q       <= cfg_xfer;
      hold_q       <= cfg_hold;
      line_clamp_q <= cfg_line_clamp;
      out_phase_q  <= cfg_out_phase;
      xfer_o       <= 1'b0;
      region_o     <= 2'd0;
      pair_o       <= '0;
    end else begin
      xfer_o   <= (st == ST_XFER);
      region_o <= region_now;
      pair_o   <= pair;
      unique case (st)
        ST_SETUP: begin
          if (cnt + ONE >= setup_q) begin st <= ST_XFER; cnt <= '0; end
          else cnt <= cnt + ONE;
        end
        ST_XFER: begin
          if (cnt + ONE >= xfer_q) begin st <= ST_HOLD; cnt <= '0; end
          else cnt <= cnt + ONE;
        end
        ST_HOLD: begin
          if (cnt + ONE >= hold_q) begin
            st    <= ST_READ;
            cnt   <= '0;
            phase <= '0;
            pair  <= '0;
          end else cnt <= cnt + ONE;
        end
        ST_READ: begin
          if (phase == LAST_PH) begin
            phase <= '0;
            if (pair == LAST_PAIR) begin
              st           <= ST_SETUP;
              pair         <= '0;
              setup_q      <= cfg_setup;
              xfer_q       <= cfg_xfer;
              hold_q       <= cfg_hold;
              line_clamp_q <= cfg_line_clamp;
              out_phase_q  <= cfg_out_phase;
            end else begin
              pair <= pair + PAIR_W'(1);
            end
          end else begin
            phase <= phase + PH_W'(1);
          end
        end
      endcase
    end
  end

  // Pulse-width counter for the transfer gate check
  logic [CNT_W-1:0] xfer_run;
  always_ff @(posedge clk) begin
    if (rst)         xfer_run <= '0;
    else if (xfer_o) xfer_run <= xfer_run + ONE;
    else             xfer_run <= '0;
  end

  // R1
  xfer_width_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(xfer_o) |-> (xfer_run == ((xfer_q == '0) ? ONE : xfer_q)));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(line_end) |-> ($stable(line_clamp_q) && $stable(out_phase_q)));

  // R4
  region_order_chk: assert property (@(posedge clk) disable iff (rst)
    (region_o != $past(region_o)) |-> (region_o == $past(region_o) + 2'd1));

endmodule

// File: rtl/lccd_chan_wave.sv
module lccd_chan_wave #(
  parameter int PIX_CYC = 10,
  parameter int PH_W    = 4,
  parameter int RST_AT  = 1,
  parameter int RST_W   = 2,
  parameter int CLP_AT  = 4,
  parameter int CLP_W   = 2,
  parameter int SMP_AT  = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reading,
  input  logic [PH_W-1:0] phase,
  input  logic            line_clamp,
  input  logic            in_ob,
  input  logic            in_valid,
  output logic            sh1_o,
  output logic            sh2_o,
  output logic            last_o,
  output logic            rg_o,
  output logic            cp_o,
  output logic            smp_o
);

  localparam int PW = PH_W + 1;
  localparam logic [PW-1:0] HALF_P = PW'(PIX_CYC / 2);
  localparam logic [PW-1:0] RG_B   = PW'(RST_AT);
  localparam logic [PW-1:0] RG_E   = PW'(RST_AT + RST_W);
  localparam logic [PW-1:0] CP_B   = PW'(CLP_AT);
  localparam logic [PW-1:0] CP_E   = PW'(CLP_AT + CLP_W);
  localparam logic [PW-1:0] SM_P   = PW'(SMP_AT);

  logic [PW-1:0] p;
  logic first_half, rg_win, cp_win;

  assign p          = {1'b0, phase};
  assign first_half = (p < HALF_P);
  assign rg_win     = (p >= RG_B) && (p < RG_E);
  assign cp_win     = (p >= CP_B) && (p < CP_E);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh1_o  <= 1'b1;
      sh2_o  <= 1'b0;
      last_o <= 1'b0;
      rg_o   <= 1'b0;
      cp_o   <= 1'b0;
      smp_o  <= 1'b0;
    end else if (!reading) begin
      sh1_o  <= 1'b1;
      sh2_o  <= 1'b0;
      last_o <= 1'b0;
      rg_o   <= 1'b0;
      cp_o   <= 1'b0;
      smp_o  <= 1'b0;
    end else begin
      sh1_o  <= first_half;
      sh2_o  <= !first_half;
      last_o <= !first_half;
      rg_o   <= rg_win;
      cp_o   <= line_clamp ? in_ob : cp_win;
      smp_o  <= in_valid && (p == SM_P);
    end
  end

  // R5
  clamp_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cp_o) |-> (!rg_o && !$past(rg_o)));

endmodule

// File: rtl/lccd_clkgen.sv
module lccd_clkgen
  import lccd_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int N_DUMMY   = 32,
  parameter int N_OB      = 96,
  parameter int N_VALID   = 7400,
  parameter int N_INVALID = 6,
  parameter int PIX_CYC   = 10,
  parameter int RST_AT    = 1,
  parameter int RST_W     = 2,
  parameter int CLP_GAP   = 1,
  parameter int CLP_W     = 2,
  parameter int SMP_AT    = 7,
  parameter int PAIR_W    = $clog2((N_DUMMY + N_OB + N_VALID + N_INVALID) / 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  cfg_setup_cyc,
  input  logic [CNT_W-1:0]  cfg_xfer_cyc,
  input  logic [CNT_W-1:0]  cfg_hold_cyc,
  input  logic              cfg_line_clamp,
  input  logic              cfg_out_phase,
  output logic              tg_o,
  output logic [1:0]        sh1_o,
  output logic [1:0]        sh2_o,
  output logic [1:0]        last_o,
  output logic [1:0]        rg_o,
  output logic [1:0]        cp_o,
  output logic [1:0]        smp_o,
  output logic [1:0]        region_o,
  output logic [PAIR_W-1:0] pair_o
);

  localparam int PH_W   = $clog2(PIX_CYC);
  localparam int CLP_AT = RST_AT + RST_W + CLP_GAP;
  localparam logic [PH_W-1:0] HALF_PH = PH_W'(PIX_CYC / 2);

  logic            reading, in_ob, in_valid, line_clamp_q, out_phase_q;
  logic [PH_W-1:0] phase, phase_rot;

  lccd_line_seq #(
    .CNT_W(CNT_W), .N_DUMMY(N_DUMMY), .N_OB(N_OB), .N_VALID(N_VALID),
    .N_INVALID(N_INVALID), .PIX_CYC(PIX_CYC), .PAIR_W(PAIR_W), .PH_W(PH_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .cfg_setup(cfg_setup_cyc), .cfg_xfer(cfg_xfer_cyc), .cfg_hold(cfg_hold_cyc),
    .cfg_line_clamp(cfg_line_clamp), .cfg_out_phase(cfg_out_phase),
    .reading(reading), .phase(phase), .in_ob(in_ob), .in_valid(in_valid),
    .line_clamp_q(line_clamp_q), .out_phase_q(out_phase_q),
    .xfer_o(tg_o), .region_o(region_o), .pair_o(pair_o)
  );

  assign phase_rot = (phase >= HALF_PH) ? (phase - HALF_PH) : (phase + HALF_PH);

  for (genvar c = 0; c < 2; c++) begin : g_chan
    logic [PH_W-1:0] ph_c;
    if (c == 0) begin : g_lead
      assign ph_c = phase;
    end else begin : g_lag
      assign ph_c = out_phase_q ? phase_rot : phase;
    end
    lccd_chan_wave #(
      .PIX_CYC(PIX_CYC), .PH_W(PH_W), .RST_AT(RST_AT), .RST_W(RST_W),
      .CLP_AT(CLP_AT), .CLP_W(CLP_W), .SMP_AT(SMP_AT)
    ) u_wave (
      .clk(clk), .rst(rst), .reading(reading), .phase(ph_c),
      .line_clamp(line_clamp_q), .in_ob(in_ob), .in_valid(in_valid),
      .sh1_o(sh1_o[c]), .sh2_o(sh2_o[c]), .last_o(last_o[c]),
      .rg_o(rg_o[c]), .cp_o(cp_o[c]), .smp_o(smp_o[c])
    );
  end

  // R3
  quiet_in_xfer_chk: assert property (@(posedge clk) disable iff (rst)
    tg_o |-> (rg_o == 2'b00 && cp_o == 2'b00 && smp_o == 2'b00));

  // R2
  shift_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    tg_o |-> (sh1_o == 2'b11 && sh2_o == 2'b00 && last_o == 2'b00));

  // R7
  split_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reading && out_phase_q) |-> (sh1_o[0] != sh1_o[1]));

  // R7
  same_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reading && !out_phase_q) |->
      (sh1_o[0] == sh1_o[1] && rg_o[0] == rg_o[1] && cp_o[0] == cp_o[1]));

  // R9
  strobe_region_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_o != 2'b00) |-> (region_o == RG_VALID));

endmodule

// File: tb/lccd_clkgen_tb.sv
module lccd_clkgen_tb;

  localparam int CNT_W = 16;
  localparam int ND = 4, NO = 4, NV = 8, NI = 2;
  localparam int P = 10, RA = 1, RW = 2, GAP = 1, CW = 2, SA = 7;
  localparam int NPAIR  = (ND + NO + NV + NI) / 2;
  localparam int PAIR_W = $clog2(NPAIR);
  localparam int HALF   = P / 2;
  localparam int CA     = RA + RW + GAP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [CNT_W-1:0]  cfg_setup_cyc, cfg_xfer_cyc, cfg_hold_cyc;
  logic              cfg_line_clamp, cfg_out_phase;
  logic              tg_o;
  logic [1:0]        sh1_o, sh2_o, last_o, rg_o, cp_o, smp_o, region_o;
  logic [PAIR_W-1:0] pair_o;

  lccd_clkgen #(
    .CNT_W(CNT_W), .N_DUMMY(ND), .N_OB(NO), .N_VALID(NV), .N_INVALID(NI),
    .PIX_CYC(P), .RST_AT(RA), .RST_W(RW), .CLP_GAP(GAP), .CLP_W(CW), .SMP_AT(SA)
  ) u_dut (
    .clk(clk), .rst(rst),
    .cfg_setup_cyc(cfg_setup_cyc), .cfg_xfer_cyc(cfg_xfer_cyc), .cfg_hold_cyc(cfg_hold_cyc),
    .cfg_line_clamp(cfg_line_clamp), .cfg_out_phase(cfg_out_phase),
    .tg_o(tg_o), .sh1_o(sh1_o), .sh2_o(sh2_o), .last_o(last_o),
    .rg_o(rg_o), .cp_o(cp_o), .smp_o(smp_o), .region_o(region_o), .pair_o(pair_o)
  );

  typedef struct {
    logic              xfer;
    logic              tg;
    logic [1:0]        sh1, sh2, lst, rg, cp, smp, rgn;
    logic [PAIR_W-1:0] pair;
    logic              lc;
    logic              pend;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   drive_en = 1'b0;
  bit   done     = 1'b0;

  // Reference model state: offset within line and the line's latched settings
  int m_o = 0;
  int m_s, m_t, m_h;
  bit m_lc, m_oop;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: computes the expected outputs of step n at edge k+n
  always @(posedge clk) begin
    if (drive_en) begin
      exp_t e;
      int   len, r, ph, pr;
      int   pc [2];
      len    = m_s + m_t + m_h + NPAIR * P;
      e.xfer = 1'b0; e.tg = 1'b0;
      e.sh1 = 2'b11; e.sh2 = 2'b00; e.lst = 2'b00;
      e.rg = 2'b00; e.cp = 2'b00; e.smp = 2'b00; e.rgn = 2'b00; e.pair = '0;
      if (m_o < m_s + m_t + m_h) begin
        e.xfer = 1'b1;
        e.tg   = (m_o >= m_s) && (m_o < m_s + m_t);
      end else begin
        r  = m_o - m_s - m_t - m_h;
        ph = r % P;
        pr = r / P;
        e.pair = PAIR_W'(pr);
        if (pr < ND / 2)                e.rgn = 2'd0;
        else if (pr < (ND + NO) / 2)    e.rgn = 2'd1;
        else if (pr < (ND + NO + NV) / 2) e.rgn = 2'd2;
        else                            e.rgn = 2'd3;
        pc[0] = ph;
        pc[1] = m_oop ? (ph + HALF) % P : ph;
        for (int c = 0; c < 2; c++) begin
          e.sh1[c] = (pc[c] < HALF);
          e.sh2[c] = (pc[c] >= HALF);
          e.lst[c] = (pc[c] >= HALF);
          e.rg[c]  = (pc[c] >= RA) && (pc[c] < RA + RW);
          e.cp[c]  = m_lc ? (e.rgn == 2'd1) : ((pc[c] >= CA) && (pc[c] < CA + CW));
          e.smp[c] = (e.rgn == 2'd2) && (pc[c] == SA);
        end
      end
      e.lc   = m_lc;
      e.pend = (cfg_line_clamp != m_lc) || (cfg_out_phase != m_oop);
      sb_q.push_back(e);
      m_o++;
      if (m_o == len) begin
        m_o   = 0;
        m_s   = int'(cfg_setup_cyc);
        m_t   = int'(cfg_xfer_cyc);
        m_h   = int'(cfg_hold_cyc);
        m_lc  = cfg_line_clamp;
        m_oop = cfg_out_phase;
      end
    end
  end

  // Monitor: compares half a cycle after each edge
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t  e;
      string cp_tag;
      e = sb_q.pop_front();
      chk("R1 transfer gate", {31'd0, tg_o}, {31'd0, e.tg});
      chk("R4 region code", {30'd0, region_o}, {30'd0, e.rgn});
      chk("R4 pair index", 32'(pair_o), 32'(e.pair));
      if (e.xfer) begin
        chk("R2 shift clocks frozen", {26'd0, sh1_o, sh2_o, last_o}, {26'd0, e.sh1, e.sh2, e.lst});
        chk("R3 reset clamp low", {26'd0, rg_o, cp_o, smp_o}, {26'd0, e.rg, e.cp, e.smp});
      end else begin
        chk("R11 readout shift odd", {29'd0, sh1_o[0], sh2_o[0], last_o[0]},
            {29'd0, e.sh1[0], e.sh2[0], e.lst[0]});
        chk("R5 reset gate odd", {31'd0, rg_o[0]}, {31'd0, e.rg[0]});
        cp_tag = e.pend ? "R8 mode held to line end" : (e.lc ? "R6 line clamp" : "R5 bit clamp");
        chk(cp_tag, {31'd0, cp_o[0]}, {31'd0, e.cp[0]});
        chk("R9 sample strobe odd", {31'd0, smp_o[0]}, {31'd0, e.smp[0]});
        chk(e.pend ? "R8 even channel mode held" : "R7 even channel clocks",
            {26'd0, sh1_o[1], sh2_o[1], last_o[1], rg_o[1], cp_o[1], smp_o[1]},
            {26'd0, e.sh1[1], e.sh2[1], e.lst[1], e.rg[1], e.cp[1], e.smp[1]});
      end
    end
  end

  task automatic set_cfg(input int s, input int t, input int h, input bit lc, input bit oop);
    cfg_setup_cyc  = CNT_W'(s);
    cfg_xfer_cyc   = CNT_W'(t);
    cfg_hold_cyc   = CNT_W'(h);
    cfg_line_clamp = lc;
    cfg_out_phase  = oop;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    set_cfg(3, 5, 3, 1'b0, 1'b0);
    m_s = 3; m_t = 5; m_h = 3; m_lc = 1'b0; m_oop = 1'b0;
    repeat (3) @(negedge clk);
    // R10: idle levels while reset is held
    chk("R10 reset tg", {31'd0, tg_o}, 32'd0);
    chk("R10 reset shift", {26'd0, sh1_o, sh2_o, last_o}, {26'd0, 2'b11, 2'b00, 2'b00});
    chk("R10 reset pulses", {26'd0, rg_o, cp_o, smp_o}, 32'd0);
    chk("R10 reset region pair", {30'd0, region_o} + 32'(pair_o), 32'd0);
    rst      = 1'b0;
    drive_en = 1'b1;
    // Mid-line switch to line clamp, split phase, longer transfer (R6, R7, R8)
    repeat (150) @(negedge clk);
    set_cfg(4, 7, 2, 1'b1, 1'b1);
    // Minimum lengths with bit clamp and split phase (R1, R2)
    repeat (260) @(negedge clk);
    set_cfg(1, 1, 1, 1'b0, 1'b1);
    // Line clamp in step
    repeat (250) @(negedge clk);
    set_cfg(2, 4, 2, 1'b1, 1'b0);
    repeat (300) @(negedge clk);
    drive_en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished at %0t", $time);
      summary();
      $finish;
    end
  end

endmodule